// File: doc/BRIEF.md
# Staged Watchdog Timer

This block is a watchdog that software arms through a small register bus and must service periodically. It counts ticks from one of up to sixteen periodic timer sources chosen in its configuration. Each time the programmed number of ticks has elapsed, an expiration is recorded. The first expiration can raise an interrupt. The fourth expiration can raise a one-clock reset request, after which counting halts.

Software keeps the system alive by stopping and restarting the counter before the fourth expiration. A start reloads the countdown and clears the expiration stage. Stopping is guarded: a disable command only acts when the write just before it placed the key value 0xC45A in the unlock register. A stray write therefore cannot silence the watchdog.

Top module: `staged_watchdog`

## Requirements
- R1: After synchronous reset the counter is stopped, the configuration and status read as zero, and both irq_out and rst_req are low.
- R2: The configuration register (address 0x0) reads back bits [15:0] of the last value written to it, with bits [31:16] zero. Reads of the command register (0x8) and the unlock register (0xC) return zero.
- R3: Writing the command register with bit 0 set starts counting. It loads the countdown with the effective period, sets the expiration stage to 0 and clears irq_out, all at the clock edge of the write.
- R4: While running, every clock cycle in which the timer source selected by configuration bits [3:0] is high decrements the countdown by one. Unselected sources have no effect.
- R5: A tick that finds the countdown at 1 is an expiration. It reloads the countdown with the effective period and increments the stage. The status register (0x4) shows the countdown in bits [11:4] and the stage in bits [13:12].
- R6: On the first expiration, irq_out goes high if configuration bit 12 is set. It stays high until a start or an accepted disable.
- R7: An expiration that finds the stage at 3 stops counting and leaves the status unchanged. If configuration bit 15 is set, it also drives rst_req high for exactly one cycle.
- R8: A command write with bit 1 set, made directly after writing 0xC45A to the unlock register, stops counting and clears irq_out. The countdown and stage are held.
- R9: Any write to another address, or an unlock write of any other value, withdraws the unlock. A disable command without a valid unlock is ignored and counting continues.
- R10: A period field (configuration bits [11:4]) of zero acts as a period of one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_src | input | 16 | Periodic tick sources, one bit per source |
| irq_out | output | 1 | Interrupt after the first expiration |
| rst_req | output | 1 | One-cycle reset request at the fourth expiration |

## Verification
The countdown is driven in three ways:
- Pulses on the selected source, which separate a correct decrement from an off-by-one reload.
- Pulses on unselected sources only, which show the source select is honoured.
- A pseudo-random mix of all sources with interleaved starts, unlocks and disables, which exposes ordering mistakes between commands and ticks in the same cycle.

Disable attempts are made with no unlock, with an intervening configuration write, and with a wrong key. This tells a properly guarded stop apart from one that only checks the key value. A zero period and a run to the fourth expiration with the reset enable both set and clear cover the boundary stages.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int PERIOD_W = 8;
    localparam int SRC_SEL_W = 4;
    localparam int STAGE_W = 2;

    // Register byte addresses; software decodes these.
    localparam logic [3:0] ADR_CFG    = 4'h0;
    localparam logic [3:0] ADR_STATUS = 4'h4;
    localparam logic [3:0] ADR_CMD    = 4'h8;
    localparam logic [3:0] ADR_UNLOCK = 4'hC;

    localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;
    localparam logic [STAGE_W-1:0] LAST_STAGE = 2'd3;

    // Configuration layout, MSB first (bit 15 down to bit 0).
    typedef struct packed {
        logic                 rst_en;
        logic [1:0]           spare;
        logic                 irq_en;
        logic [PERIOD_W-1:0]  period;
        logic [SRC_SEL_W-1:0] src;
    } wdg_cfg_t;

    typedef struct packed {
        logic                start;
        logic                stop;
    } wdg_cmd_t;

    function automatic logic [PERIOD_W-1:0] eff_period(input logic [PERIOD_W-1:0] p);
        return (p == '0) ? PERIOD_W'(1) : p;
    endfunction

endpackage

// File: rtl/wdg_tick_sel.sv
module wdg_tick_sel #(
    parameter int SRC_N = 16
) (
    input  logic [SRC_N-1:0]               tick_src_i,
    input  logic [wdg_pkg::SRC_SEL_W-1:0]  src_i,
    output logic                           tick_o
);
    logic [SRC_N-1:0] hit;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        assign hit[i] = tick_src_i[i] && (src_i == wdg_pkg::SRC_SEL_W'(i));
    end

    assign tick_o = |hit;
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                we_i,
    input  logic [PERIOD_W-1:0] count_i,
    input  logic [STAGE_W-1:0]  stage_i,
    output wdg_cfg_t            cfg_o,
    output wdg_cmd_t            cmd_o,
    output logic [DATA_W-1:0]   rdata_o
);
    wdg_cfg_t cfg_q;
    logic     unl_q;
    logic     wr_cfg, wr_cmd, wr_unl;

    assign wr_cfg = we_i && (addr_i == ADDR_W'(ADR_CFG));
    assign wr_cmd = we_i && (addr_i == ADDR_W'(ADR_CMD));
    assign wr_unl = we_i && (addr_i == ADDR_W'(ADR_UNLOCK));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            unl_q <= 1'b0;
        end else begin
            if (wr_cfg) cfg_q <= wdg_cfg_t'(wdata_i[15:0]);
            if (we_i)   unl_q <= wr_unl && (wdata_i == DATA_W'(UNLOCK_KEY));
        end
    end

    assign cmd_o.start = wr_cmd && wdata_i[0];
    assign cmd_o.stop  = wr_cmd && wdata_i[1] && unl_q;
    assign cfg_o       = cfg_q;

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADR_CFG))
            rdata_o[15:0] = cfg_q;
        else if (addr_i == ADDR_W'(ADR_STATUS))
            rdata_o[13:0] = {stage_i, count_i, 4'b0000};
    end

    // R9: the unlock never survives a non-unlock write
    a_r9_unlock_drop: assert property (@(posedge clk) disable iff (rst)
        (we_i && !wr_unl) |=> !unl_q);
    // R2: configuration only changes on its own write
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_cfg |=> $stable(cfg_q));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  wdg_cmd_t            cmd_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                irq_en_i,
    input  logic                rst_en_i,
    output logic [PERIOD_W-1:0] count_o,
    output logic [STAGE_W-1:0]  stage_o,
    output logic                irq_o,
    output logic                rst_req_o
);
    logic                run_q, irq_q, rreq_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [STAGE_W-1:0]  stage_q;
    logic                expire;

    assign expire = run_q && tick_i && (cnt_q <= PERIOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            irq_q   <= 1'b0;
            rreq_q  <= 1'b0;
            cnt_q   <= '0;
            stage_q <= '0;
        end else begin
            rreq_q <= 1'b0;
            if (cmd_i.stop) begin
                run_q <= 1'b0;
                irq_q <= 1'b0;
            end else if (cmd_i.start) begin
                run_q   <= 1'b1;
                irq_q   <= 1'b0;
                cnt_q   <= eff_period(period_i);
                stage_q <= '0;
            end else if (expire) begin
                if (stage_q == LAST_STAGE) begin
                    run_q  <= 1'b0;
                    rreq_q <= rst_en_i;
                end else begin
                    stage_q <= stage_q + STAGE_W'(1);
                    cnt_q   <= eff_period(period_i);
                    if (stage_q == '0 && irq_en_i) irq_q <= 1'b1;
                end
            end else if (run_q && tick_i) begin
                cnt_q <= cnt_q - PERIOD_W'(1);
            end
        end
    end

    assign count_o   = cnt_q;
    assign stage_o   = stage_q;
    assign irq_o     = irq_q;
    assign rst_req_o = rreq_q;

    // R7: the reset request is a single-cycle pulse
    a_r7_rst_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rreq_q |=> !rreq_q);
    // R7: the reset request is only raised at the final stage and counting has stopped
    a_r7_rst_final: assert property (@(posedge clk) disable iff (rst)
        rreq_q |-> (stage_q == LAST_STAGE) && !run_q);
    // R6: the interrupt rises only on entering the first expired stage
    a_r6_irq_first: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> stage_q == STAGE_W'(1));
    // R5: a running countdown never shows zero
    a_r5_count_live: assert property (@(posedge clk) disable iff (rst)
        run_q |-> cnt_q != '0);
    // R4: a stopped counter holds its countdown until started
    a_r4_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cmd_i.start) |=> $stable(cnt_q));
    // R9: without a stop command or a tick, counting continues
    a_r9_keep_running: assert property (@(posedge clk) disable iff (rst)
        (run_q && !cmd_i.stop && !tick_i) |=> run_q);
endmodule

// File: rtl/staged_watchdog.sv
module staged_watchdog
    import wdg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int SRC_N  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  tick_src,
    output logic              irq_out,
    output logic              rst_req
);
    wdg_cfg_t            cfg;
    wdg_cmd_t            cmd;
    logic                tick;
    logic [PERIOD_W-1:0] count;
    logic [STAGE_W-1:0]  stage;

    wdg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .we_i(bus_we), .count_i(count), .stage_i(stage),
        .cfg_o(cfg), .cmd_o(cmd), .rdata_o(bus_rdata)
    );

    wdg_tick_sel #(.SRC_N(SRC_N)) u_sel (
        .tick_src_i(tick_src), .src_i(cfg.src), .tick_o(tick)
    );

    wdg_counter u_cnt (
        .clk(clk), .rst(rst), .cmd_i(cmd), .tick_i(tick),
        .period_i(cfg.period), .irq_en_i(cfg.irq_en), .rst_en_i(cfg.rst_en),
        .count_o(count), .stage_o(stage), .irq_o(irq_out), .rst_req_o(rst_req)
    );
endmodule

// File: tb/staged_watchdog_test.sv
module staged_watchdog_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        we;
    logic [15:0] tsrc;
    logic [31:0] rdata;
    logic        irq, rreq;

    int checks = 0;
    int fails = 0;
    int rst_seen = 0;

    always #5 clk = ~clk;

    staged_watchdog uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
        .bus_rdata(rdata), .tick_src(tsrc), .irq_out(irq), .rst_req(rreq)
    );

    // Behavioural reference model
    int m_run, m_cnt, m_stage, m_irq, m_rst, m_unl, m_eff;
    logic [15:0] m_cfg;
    bit m_tk, m_stp, m_stt;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_cnt = 0; m_stage = 0; m_irq = 0; m_rst = 0; m_unl = 0;
            m_cfg = 16'h0;
        end else begin
            m_tk  = tsrc[m_cfg[3:0]];
            m_eff = (m_cfg[11:4] == 0) ? 1 : int'(m_cfg[11:4]);
            m_stp = we && addr == 4'h8 && wdata[1] && (m_unl != 0);
            m_stt = we && addr == 4'h8 && wdata[0];
            m_rst = 0;
            if (m_stp) begin
                m_run = 0; m_irq = 0;
            end else if (m_stt) begin
                m_run = 1; m_irq = 0; m_cnt = m_eff; m_stage = 0;
            end else if (m_run != 0 && m_tk) begin
                if (m_cnt == 1) begin
                    if (m_stage == 3) begin
                        m_run = 0; m_rst = m_cfg[15];
                    end else begin
                        if (m_stage == 0 && m_cfg[12]) m_irq = 1;
                        m_stage = m_stage + 1; m_cnt = m_eff;
                    end
                end else m_cnt = m_cnt - 1;
            end
            if (we) begin
                if (addr == 4'h0) m_cfg = wdata[15:0];
                m_unl = (addr == 4'hC && wdata == 32'h0000C45A) ? 1 : 0;
            end
        end
    end

    function automatic logic [31:0] mread(input logic [3:0] a);
        if (a == 4'h0) return {16'h0, m_cfg};
        if (a == 4'h4) return 32'(m_stage * 4096 + m_cnt * 16);
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [3:0] a, input logic [31:0] d, input bit w, input logic [15:0] t);
        addr = a; wdata = d; we = w; tsrc = t;
        @(posedge clk);
        @(negedge clk);
        chk(irq == m_irq[0], "R6 irq vs model", 32'(irq), 32'(m_irq));
        chk(rreq == m_rst[0], "R7 rst_req vs model", 32'(rreq), 32'(m_rst));
        chk(rdata == mread(addr), "R5 rdata vs model", rdata, mread(addr));
        if (rreq) rst_seen++;
        we = 1'b0; tsrc = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(a, d, 1'b1, 16'h0);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) cyc(4'h4, 32'h0, 1'b0, 16'h0004);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        cyc(a, 32'h0, 1'b0, 16'h0);
        chk(rdata == exp, req, rdata, exp);
    endtask

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog timeout R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        rst = 1'b1; addr = 4'h4; wdata = '0; we = 1'b0; tsrc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        rd(4'h4, 32'h0, "R1 status after reset");
        rd(4'h0, 32'h0, "R1 config after reset");
        chk(irq == 1'b0 && rreq == 1'b0, "R1 outputs low", 32'({irq, rreq}), 32'h0);

        // cfg: src 2, period 3, irq enable, reset enable
        wr(4'h0, 32'hFFFF_9032);
        rd(4'h0, 32'h0000_9032, "R2 config readback");
        rd(4'h8, 32'h0, "R2 command reads zero");
        wr(4'hC, 32'h0000_1234);
        rd(4'hC, 32'h0, "R2 unlock reads zero");

        wr(4'h8, 32'h1);
        rd(4'h4, 32'h30, "R3 start loads period");
        for (int i = 0; i < 4; i++) cyc(4'h4, 32'h0, 1'b0, 16'h0020);
        rd(4'h4, 32'h30, "R4 unselected source ignored");
        tk(1);
        rd(4'h4, 32'h20, "R4 decrement");
        tk(2);
        rd(4'h4, 32'h1030, "R5 first expiration reload");
        chk(irq == 1'b1, "R6 irq on first expiration", 32'(irq), 32'h1);

        wr(4'h8, 32'h2);
        tk(1);
        rd(4'h4, 32'h1020, "R9 disable without unlock ignored");
        wr(4'hC, 32'h0000_C45A); wr(4'h0, 32'h9032); wr(4'h8, 32'h2);
        chk(irq == 1'b1, "R9 intervening write drops unlock", 32'(irq), 32'h1);
        wr(4'hC, 32'h0000_C45B); wr(4'h8, 32'h2);
        tk(1);
        rd(4'h4, 32'h1010, "R9 wrong key rejected");

        tk(7);
        rd(4'h4, 32'h3010, "R7 halted at last stage");
        chk(rst_seen == 1, "R7 one reset pulse", 32'(rst_seen), 32'h1);
        tk(3);
        rd(4'h4, 32'h3010, "R7 no counting after halt");

        wr(4'h8, 32'h1);
        chk(irq == 1'b0, "R3 start clears irq", 32'(irq), 32'h0);
        rd(4'h4, 32'h30, "R3 restart reload");
        tk(3);
        chk(irq == 1'b1, "R6 irq again", 32'(irq), 32'h1);
        wr(4'hC, 32'h0000_C45A); wr(4'h8, 32'h2);
        chk(irq == 1'b0, "R8 accepted disable clears irq", 32'(irq), 32'h0);
        tk(2);
        rd(4'h4, 32'h1030, "R8 stopped counter holds");

        wr(4'h0, 32'h0000_0002);
        wr(4'h8, 32'h1);
        rd(4'h4, 32'h10, "R10 zero period loads one");
        tk(1);
        rd(4'h4, 32'h1010, "R10 one tick per expiration");
        chk(irq == 1'b0, "R6 no irq when disabled", 32'(irq), 32'h0);
        tk(3);
        rd(4'h4, 32'h3010, "R7 last stage reached");
        chk(rst_seen == 1, "R7 no pulse without enable", 32'(rst_seen), 32'h1);

        wr(4'h0, 32'h0000_9022);
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i % 50 == 0) wr(4'h8, 32'h1);
            else if (i % 71 == 0) wr(4'hC, 32'h0000_C45A);
            else if (i % 71 == 1) wr(4'h8, 32'h2);
            else if (i % 97 == 5) wr(4'h8, 32'h3);
            else cyc((i % 3 == 0) ? 4'h0 : 4'h4, 32'h0, 1'b0, lf);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule